// File: doc/BRIEF.md
# GPIO Interrupt-on-Change Controller

This block watches an 8-bit input port and raises an interrupt when a pin changes. Each pin has its own enable bit and a compare-mode bit. In edge mode, a pin fires when its level differs from the level sampled on the cycle before. In level mode, a pin fires while its level differs from a per-pin default bit. Before any comparison, the raw pin levels pass through a per-pin polarity inversion. The compare and the capture therefore see the same value that the port register returns.

The first event of an interrupt records a snapshot of the whole port in a capture register. Later events only add bits to the flag register, until the register interface sends a clear pulse. That pulse is sent when the capture register or the port register is read. The interrupt pin can work in three ways: push-pull active-high, push-pull active-low, or open-drain. Open-drain is shown as an output enable that pulls low.

Top module: `ioc_ctrl`

## Requirements
- R1: A pin can set a flag only when its direction bit is 1 (input) and its enable bit is 1. Pins with direction 0 (output) and disabled pins never affect the flags or the interrupt.
- R2: When a pin's compare-mode bit is 1, the pin is in an interrupt condition while its adjusted level differs from its default bit.
- R3: When a pin's compare-mode bit is 0, the pin is in an interrupt condition when its adjusted level differs from the level sampled one clock earlier. The reference then follows the new level.
- R4: With no interrupt pending, the first condition has three effects, all visible after the next rising clock edge. The flag register becomes the set of pins in condition. The capture register takes the whole adjusted port value. The interrupt becomes active.
- R5: While an interrupt is pending and no clear arrives, new conditions OR their bits into the flags. The capture register stays unchanged and no new interrupt starts.
- R6: A clear pulse empties the flags and ends the interrupt, provided no pin is in condition in that cycle. The capture register keeps its value. Only the clear pulse ends an interrupt.
- R7: If a level-mode mismatch still exists when the clear pulse arrives, the interrupt stays active. The flags hold the pins that are still in condition, and the capture register reloads with the current port value.
- R8: Output encoding depends on the open-drain bit. With open-drain = 1: irq_out = 0 and irq_oe = active. With open-drain = 0: irq_oe = 1 and irq_out = active when active_high = 1, or irq_out = not active when active_high = 0.
- R9: After reset, the flags and the capture register are 0 and the interrupt is inactive.
- R10: port_val = pin_in XOR pol_inv. The compare and the capture both use this adjusted value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 8 | Synchronized pin levels |
| dir | input | 8 | Per-pin direction, 1 = input |
| pol_inv | input | 8 | Per-pin polarity inversion |
| irq_en | input | 8 | Per-pin interrupt enable |
| def_val | input | 8 | Per-pin default compare bit |
| cmp_mode | input | 8 | 1 = compare with default, 0 = compare with previous |
| od_mode | input | 1 | 1 = open-drain interrupt pin |
| act_high | input | 1 | Push-pull polarity, 1 = active-high |
| clr_rd | input | 1 | One-cycle pulse on a read of the capture or port register |
| port_val | output | 8 | Polarity-adjusted port value |
| flags | output | 8 | Interrupt flag register |
| capture | output | 8 | Port snapshot taken at the first event |
| irq_active | output | 1 | Interrupt pending |
| irq_out | output | 1 | Interrupt pin drive level |
| irq_oe | output | 1 | Interrupt pin drive enable |

## Verification
The assertions assume two things about the inputs. First, clr_rd is a single-cycle pulse produced by the register interface. Second, pin_in, dir and the configuration change only between clock edges, because pin_in is already synchronized. The stimulus changes all inputs on the falling edge and holds each clear high for exactly one cycle. It also keeps the enables at zero until the reference register has settled after reset, so the first compare does not see a false edge.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

    typedef enum logic [1:0] {
        DRV_PP_LOW  = 2'd0,
        DRV_PP_HIGH = 2'd1,
        DRV_OPEN    = 2'd2
    } drv_mode_e;

    function automatic drv_mode_e pick_mode(input logic open_drain, input logic high);
        if (open_drain)
            return DRV_OPEN;
        else if (high)
            return DRV_PP_HIGH;
        else
            return DRV_PP_LOW;
    endfunction

endpackage

// File: rtl/ioc_detect.sv
module ioc_detect #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_raw,
    input  logic [WIDTH-1:0] pol_inv,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] en,
    input  logic [WIDTH-1:0] def_val,
    input  logic [WIDTH-1:0] mode,
    output logic [WIDTH-1:0] adj_val,
    output logic [WIDTH-1:0] hit
);

    logic [WIDTH-1:0] ref_d, ref_q;

    // polarity is applied once, shared by compare and capture
    assign adj_val = pin_raw ^ pol_inv;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic mism;
            assign mism   = mode[i] ? (adj_val[i] != def_val[i])
                                    : (adj_val[i] != ref_q[i]);
            assign hit[i] = dir[i] & en[i] & mism;
        end
    endgenerate

    always_comb begin
        ref_d = adj_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_q <= '0;
        else
            ref_q <= ref_d;
    end

    // a pin held in edge mode with no change cannot keep firing (R3)
    assert_edge_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[0] == 1'b0 && $stable(pin_raw) && $stable(pol_inv) && $past(rst_n))
            |-> !hit[0]);

endmodule

// File: rtl/ioc_capture.sv
module ioc_capture #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] hit,
    input  logic [WIDTH-1:0] adj_val,
    input  logic             clr_rd,
    output logic [WIDTH-1:0] flags,
    output logic [WIDTH-1:0] capture,
    output logic             active
);

    typedef struct packed {
        logic [WIDTH-1:0] flg;
        logic [WIDTH-1:0] cap;
        logic             act;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_rd || !st_q.act) begin
            // idle or cleared: a fresh interrupt starts only from live conditions
            st_d.flg = hit;
            st_d.act = |hit;
            if (|hit)
                st_d.cap = adj_val;
        end else begin
            st_d.flg = st_q.flg | hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign flags   = st_q.flg;
    assign capture = st_q.cap;
    assign active  = st_q.act;

    assert_cap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && !clr_rd) |=> $stable(st_q.cap));

    assert_flags_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && !clr_rd) |=> ((st_q.flg & $past(st_q.flg)) == $past(st_q.flg)) && st_q.act);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd && hit == '0) |=> (!st_q.act && st_q.flg == '0));

    assert_flag_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flg != '0) |-> st_q.act);

endmodule

// File: rtl/ioc_drive.sv
module ioc_drive
    import ioc_pkg::*;
(
    input  logic active,
    input  logic od_mode,
    input  logic act_high,
    output logic irq_out,
    output logic irq_oe
);

    drv_mode_e dm;

    always_comb begin
        dm = pick_mode(od_mode, act_high);
        unique case (dm)
            DRV_OPEN: begin
                irq_out = 1'b0;
                irq_oe  = active;
            end
            DRV_PP_HIGH: begin
                irq_out = active;
                irq_oe  = 1'b1;
            end
            default: begin
                irq_out = ~active;
                irq_oe  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ioc_ctrl.sv
module ioc_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] pol_inv,
    input  logic [WIDTH-1:0] irq_en,
    input  logic [WIDTH-1:0] def_val,
    input  logic [WIDTH-1:0] cmp_mode,
    input  logic             od_mode,
    input  logic             act_high,
    input  logic             clr_rd,
    output logic [WIDTH-1:0] port_val,
    output logic [WIDTH-1:0] flags,
    output logic [WIDTH-1:0] capture,
    output logic             irq_active,
    output logic             irq_out,
    output logic             irq_oe
);

    logic [WIDTH-1:0] hit;

    ioc_detect #(.WIDTH(WIDTH)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_raw (pin_in),
        .pol_inv (pol_inv),
        .dir     (dir),
        .en      (irq_en),
        .def_val (def_val),
        .mode    (cmp_mode),
        .adj_val (port_val),
        .hit     (hit)
    );

    ioc_capture #(.WIDTH(WIDTH)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .adj_val (port_val),
        .clr_rd  (clr_rd),
        .flags   (flags),
        .capture (capture),
        .active  (irq_active)
    );

    ioc_drive u_drive (
        .active   (irq_active),
        .od_mode  (od_mode),
        .act_high (act_high),
        .irq_out  (irq_out),
        .irq_oe   (irq_oe)
    );

    assert_src_inputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_active || clr_rd) |=> ((flags & ~$past(dir & irq_en)) == '0));

    assert_open_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        od_mode |-> (irq_out == 1'b0 && irq_oe == irq_active));

    assert_push_pull_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !od_mode |-> (irq_oe && (irq_out == (act_high == irq_active))));

endmodule

// File: tb/ioc_ctrl_test.sv
module ioc_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = '0, dir = 8'hFF, pol_inv = '0, irq_en = '0;
    logic [7:0] def_val = '0, cmp_mode = '0;
    logic       od_mode = 1'b0, act_high = 1'b0, clr_rd = 1'b0;
    logic [7:0] port_val, flags, capture;
    logic       irq_active, irq_out, irq_oe;

    int total = 0, bad = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] f, c, p;
        logic       a, o, e;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    ioc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .dir(dir), .pol_inv(pol_inv),
        .irq_en(irq_en), .def_val(def_val), .cmp_mode(cmp_mode), .od_mode(od_mode),
        .act_high(act_high), .clr_rd(clr_rd), .port_val(port_val), .flags(flags),
        .capture(capture), .irq_active(irq_active), .irq_out(irq_out), .irq_oe(irq_oe)
    );

    // expected pin encoding from R8, using the mode in force for that cycle
    task automatic push(input string tag, input logic [7:0] f, input logic [7:0] c,
                        input logic [7:0] p, input logic a);
        exp_t it;
        it.tag = tag; it.f = f; it.c = c; it.p = p; it.a = a;
        it.e = od_mode ? a : 1'b1;
        it.o = od_mode ? 1'b0 : (act_high ? a : ~a);
        q.push_back(it);
    endtask

    task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: compares one expected item per cycle, after the edge settles
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                cmp(it.tag, "flags", flags, it.f);
                cmp(it.tag, "capture", capture, it.c);
                cmp(it.tag, "port", port_val, it.p);
                cmp(it.tag, "active", {7'd0, irq_active}, {7'd0, it.a});
                cmp(it.tag, "irq_out", {7'd0, irq_out}, {7'd0, it.o});
                cmp(it.tag, "irq_oe", {7'd0, irq_oe}, {7'd0, it.e});
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push("R9", 8'h00, 8'h00, 8'h00, 1'b0);
        @(negedge clk); dir = 8'h0F; irq_en = 8'hFF;
        push("R9", 8'h00, 8'h00, 8'h00, 1'b0);
        // R1: only output pins toggle
        @(negedge clk); pin_in = 8'hF0;
        push("R1", 8'h00, 8'h00, 8'hF0, 1'b0);
        // R3/R4: edge on input bit0
        @(negedge clk); pin_in = 8'hF1;
        push("R4", 8'h01, 8'hF1, 8'hF1, 1'b1);
        // R5: second event while pending
        @(negedge clk); pin_in = 8'hF3;
        push("R5", 8'h03, 8'hF1, 8'hF3, 1'b1);
        @(negedge clk);
        push("R5", 8'h03, 8'hF1, 8'hF3, 1'b1);
        // R6: clear read
        @(negedge clk); clr_rd = 1'b1;
        push("R6", 8'h00, 8'hF1, 8'hF3, 1'b0);
        @(negedge clk); clr_rd = 1'b0;
        push("R3", 8'h00, 8'hF1, 8'hF3, 1'b0);
        // R2: default compare on low nibble, default 00
        @(negedge clk); cmp_mode = 8'h0F;
        push("R2", 8'h03, 8'hF3, 8'hF3, 1'b1);
        // R7: mismatch survives the clear
        @(negedge clk); clr_rd = 1'b1;
        push("R7", 8'h03, 8'hF3, 8'hF3, 1'b1);
        @(negedge clk); clr_rd = 1'b0; def_val = 8'h03;
        push("R7", 8'h03, 8'hF3, 8'hF3, 1'b1);
        @(negedge clk); clr_rd = 1'b1;
        push("R6", 8'h00, 8'hF3, 8'hF3, 1'b0);
        // R10: inversion on bit0 seen as edge, capture holds adjusted value
        @(negedge clk); clr_rd = 1'b0; cmp_mode = 8'h00; pol_inv = 8'h01;
        push("R10", 8'h01, 8'hF2, 8'hF2, 1'b1);
        @(negedge clk); clr_rd = 1'b1;
        push("R6", 8'h00, 8'hF2, 8'hF2, 1'b0);
        // R8: open-drain released, then pulling
        @(negedge clk); clr_rd = 1'b0; od_mode = 1'b1;
        push("R8", 8'h00, 8'hF2, 8'hF2, 1'b0);
        @(negedge clk); pin_in = 8'hF0;
        push("R8", 8'h03, 8'hF1, 8'hF1, 1'b1);
        @(negedge clk); od_mode = 1'b0; act_high = 1'b1;
        push("R8", 8'h03, 8'hF1, 8'hF1, 1'b1);
        @(negedge clk); clr_rd = 1'b1;
        push("R8", 8'h00, 8'hF1, 8'hF1, 1'b0);
        // R1: disabled input pin changes
        @(negedge clk); clr_rd = 1'b0; irq_en = 8'hFE; pin_in = 8'hF1;
        push("R1", 8'h00, 8'hF1, 8'hF0, 1'b0);
        @(negedge clk);
        push("R1", 8'h00, 8'hF1, 8'hF0, 1'b0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule